// File: doc/BRIEF.md
# Audio Serial Port Clock Generator

This block produces the three clocks of a stereo audio serial port: a master clock, a bit clock and a word-select clock. It derives them from one of three reference clocks. Each reference enters as a single-cycle strobe, synchronous to the block's system clock, that marks one edge of that reference; the block counts these strobes. A format word sets the reference, two divider codes, the frame length and whether the port drives the bit and word clocks or leaves them to an external source.

Software stops the clocks by clearing a level enable. The block finishes the current frame and holds every clock low for one reference strobe. It then releases the output enables and raises a sticky stopped status, which is cleared by writing one to it. A format written while the clocks run is held and takes effect at the next stop. Restarting always begins a fresh frame.

Top module: `aclk_gen`

## Requirements
- R1: After reset all clock outputs are low, all three output enables are low and the stopped status is low.
- R2: Format bits [1:0] pick the reference strobe: 0, 1 and 2 select ref_tick[0], [1] and [2]; code 3 acts as code 2.
- R3: Format bits [6:2] set the master divisor M: code 0x14 gives 1, 0x13 gives 3, 0x12 gives 5, and any other code n gives 2*(n+1). mclk_o has a period of 2*M reference strobes, low for the first M and high for the last M.
- R4: Format bits [10:7] set the bit-clock divisor B in master-clock periods: code 0x8 gives 1, 0x9 gives 3, and any other code n gives 2*(n+1). bclk_o is low for the first half of each period.
- R5: Format bit 11 sets the frame length: 0 gives 32 and 1 gives 64 bit-clock periods per word-select period. wclk_o is low for the first half of each frame.
- R6: While running, mclk_oe is high. Format bit 12 set to 1 raises bclk_oe and wclk_oe together with it; set to 0 it keeps them low while the bit and word levels keep counting.
- R7: Once clk_en falls, the clocks keep running to the end of the current frame before they stop.
- R8: At the end of that frame all clock outputs are held low, with the enables still high, for one reference strobe. Then all enables fall.
- R9: stop_pend rises together with the enables falling and stays high until a cycle with stop_clr high.
- R10: A format write while the clocks are stopped takes effect at once. A write while they run changes nothing until the next stop completes.
- R11: A restart resets all divider counters. The first frame begins with wclk_o low, and wclk_o first rises after exactly half a frame of bit-clock rising edges.
- R12: Raising clk_en again before the draining frame ends cancels the stop: the enables stay high and stop_pend stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 3 | One strobe per reference, each marking one reference edge |
| cfg_wr | input | 1 | Format write strobe |
| cfg_data | input | 13 | Format word |
| clk_en | input | 1 | Level enable for the clocks |
| stop_clr | input | 1 | Clears stop_pend (write-one-to-clear) |
| stop_pend | output | 1 | Sticky clocks-stopped status |
| mclk_o | output | 1 | Master clock level |
| mclk_oe | output | 1 | Master clock drive enable |
| bclk_o | output | 1 | Bit clock level |
| bclk_oe | output | 1 | Bit clock drive enable |
| wclk_o | output | 1 | Word-select clock level |
| wclk_oe | output | 1 | Word-select clock drive enable |

## Verification
The bench measures periods for every special odd divisor code and for the generic codes, and checks that select code 3 aliases code 2. A decoder that treated an odd code as generic would show the wrong period. The bench clears the enable just as word select rises and counts the remaining bit-clock edges; a stop that ignored the frame boundary would show fewer than 16. It also checks that the outputs are low in the sample before the enables drop. A format written mid-run must leave the measured period unchanged, and a restart must give a full half frame before word select rises. A design that applied the write early, or kept stale counters, would fail those two checks.

// File: rtl/aclk_pkg.sv
package aclk_pkg;
  localparam int SRC_W   = 2;
  localparam int MCODE_W = 5;
  localparam int BCODE_W = 4;
  // counters must hold twice the largest divisor
  localparam int CNT_W   = MCODE_W + 3;
  localparam int BIT_W   = 7;

  typedef struct packed {
    logic               master;
    logic               frame64;
    logic [BCODE_W-1:0] bcode;
    logic [MCODE_W-1:0] mcode;
    logic [SRC_W-1:0]   src;
  } fmt_t;

  localparam int FMT_W = $bits(fmt_t);

  localparam logic [MCODE_W-1:0] MC_BY1 = MCODE_W'(5'h14);
  localparam logic [MCODE_W-1:0] MC_BY3 = MCODE_W'(5'h13);
  localparam logic [MCODE_W-1:0] MC_BY5 = MCODE_W'(5'h12);
  localparam logic [BCODE_W-1:0] BC_BY1 = BCODE_W'(4'h8);
  localparam logic [BCODE_W-1:0] BC_BY3 = BCODE_W'(4'h9);

  typedef enum logic [1:0] {ST_OFF, ST_RUN, ST_DRAIN, ST_PARK} seq_st_t;

  function automatic logic [CNT_W-1:0] mclk_ratio(input logic [MCODE_W-1:0] c);
    case (c)
      MC_BY1:  return CNT_W'(1);
      MC_BY3:  return CNT_W'(3);
      MC_BY5:  return CNT_W'(5);
      default: return (CNT_W'(c) << 1) + CNT_W'(2);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] bclk_ratio(input logic [BCODE_W-1:0] c);
    case (c)
      BC_BY1:  return CNT_W'(1);
      BC_BY3:  return CNT_W'(3);
      default: return (CNT_W'(c) << 1) + CNT_W'(2);
    endcase
  endfunction
endpackage

// File: rtl/aclk_cfg.sv
module aclk_cfg
  import aclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [FMT_W-1:0] wdata,
  input  logic             off,
  input  logic             apply,
  output fmt_t             active
);
  fmt_t held;
  logic held_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= '0;
      held   <= '0;
      held_v <= 1'b0;
    end else if (apply) begin
      // stop completes: newest write wins, else the held one
      if (wr)          active <= fmt_t'(wdata);
      else if (held_v) active <= held;
      held_v <= 1'b0;
    end else if (wr) begin
      if (off) begin
        active <= fmt_t'(wdata);
        held_v <= 1'b0;
      end else begin
        held   <= fmt_t'(wdata);
        held_v <= 1'b1;
      end
    end
  end

  // R10: the live format stays put unless stopped or at the stop instant
  a_r10_hold_while_live: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(off) && !$past(apply)) |-> $stable(active));
endmodule

// File: rtl/aclk_divchain.sv
module aclk_divchain
  import aclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             clear,
  input  logic [CNT_W-1:0] m_ratio,
  input  logic [CNT_W-1:0] b_ratio,
  input  logic             frame64,
  output logic             mclk_lvl,
  output logic             bclk_lvl,
  output logic             wclk_lvl,
  output logic             frame_end
);
  logic [CNT_W-1:0] mc, bc;
  logic [BIT_W-1:0] bitc;
  logic [CNT_W-1:0] m_span, b_span;
  logic [BIT_W-1:0] f_len, f_half;
  logic step, m_wrap, m_half, b_wrap, bit_last;

  assign m_span   = m_ratio << 1;
  assign b_span   = b_ratio << 1;
  assign f_len    = frame64 ? BIT_W'(64) : BIT_W'(32);
  assign f_half   = frame64 ? BIT_W'(32) : BIT_W'(16);
  assign step     = tick & run;
  assign m_wrap   = (mc == m_span - CNT_W'(1));
  assign m_half   = step & (m_wrap | (mc == m_ratio - CNT_W'(1)));
  assign b_wrap   = (bc == b_span - CNT_W'(1));
  assign bit_last = (bitc == f_len - BIT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      mc   <= '0;
      bc   <= '0;
      bitc <= '0;
    end else if (step) begin
      mc <= m_wrap ? '0 : mc + CNT_W'(1);
      if (m_half) begin
        bc <= b_wrap ? '0 : bc + CNT_W'(1);
        if (b_wrap) bitc <= bit_last ? '0 : bitc + BIT_W'(1);
      end
    end
  end

  assign mclk_lvl  = (mc >= m_ratio);
  assign bclk_lvl  = (bc >= b_ratio);
  assign wclk_lvl  = (bitc >= f_half);
  assign frame_end = m_half & b_wrap & bit_last;

  // R5: word select only moves on a falling bit clock
  a_r5_word_on_bit_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && !$past(clear) && $changed(wclk_lvl)) |-> $fell(bclk_lvl));
  // R4: bit clock only moves together with a master clock edge
  a_r4_bit_on_master_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && !$past(clear) && $changed(bclk_lvl)) |-> $changed(mclk_lvl));
endmodule

// File: rtl/aclk_seq.sv
module aclk_seq
  import aclk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clk_en,
  input  logic frame_end,
  input  logic stop_clr,
  output logic run,
  output logic clear,
  output logic drive,
  output logic park,
  output logic apply,
  output logic stop_pend
);
  seq_st_t st, nxt;

  always_comb begin
    nxt = st;
    case (st)
      ST_OFF:   if (clk_en) nxt = ST_RUN;
      ST_RUN:   if (!clk_en) nxt = ST_DRAIN;
      ST_DRAIN: if (clk_en) nxt = ST_RUN;
                else if (frame_end) nxt = ST_PARK;
      ST_PARK:  if (tick) nxt = ST_OFF;
      default:  nxt = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_OFF;
      stop_pend <= 1'b0;
    end else begin
      st <= nxt;
      if (apply)         stop_pend <= 1'b1;
      else if (stop_clr) stop_pend <= 1'b0;
    end
  end

  assign run   = (st == ST_RUN) || (st == ST_DRAIN);
  assign clear = (st == ST_OFF);
  assign drive = (st != ST_OFF);
  assign park  = (st == ST_PARK);
  assign apply = park & tick;

  // R7: parking is only ever entered on a frame boundary
  a_r7_park_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(park) |-> $past(frame_end));
  // R9: completing a stop leaves the status set
  a_r9_status_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> stop_pend);
endmodule

// File: rtl/aclk_gen.sv
module aclk_gen
  import aclk_pkg::*;
#(
  parameter int NREF = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NREF-1:0]     ref_tick,
  input  logic                cfg_wr,
  input  logic [FMT_W-1:0]    cfg_data,
  input  logic                clk_en,
  input  logic                stop_clr,
  output logic                stop_pend,
  output logic                mclk_o,
  output logic                mclk_oe,
  output logic                bclk_o,
  output logic                bclk_oe,
  output logic                wclk_o,
  output logic                wclk_oe
);
  fmt_t act;
  logic tk, run, clear, drive, park, apply, frame_end;
  logic m_lvl, b_lvl, w_lvl;

  // codes past the last reference alias the last one
  always_comb begin
    tk = ref_tick[NREF-1];
    for (int i = 0; i < NREF; i++)
      if (act.src == SRC_W'(i)) tk = ref_tick[i];
  end

  aclk_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_data),
    .off(clear), .apply(apply), .active(act)
  );

  aclk_seq u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tk), .clk_en(clk_en),
    .frame_end(frame_end), .stop_clr(stop_clr), .run(run), .clear(clear),
    .drive(drive), .park(park), .apply(apply), .stop_pend(stop_pend)
  );

  aclk_divchain u_div (
    .clk(clk), .rst_n(rst_n), .tick(tk), .run(run), .clear(clear),
    .m_ratio(mclk_ratio(act.mcode)), .b_ratio(bclk_ratio(act.bcode)),
    .frame64(act.frame64), .mclk_lvl(m_lvl), .bclk_lvl(b_lvl),
    .wclk_lvl(w_lvl), .frame_end(frame_end)
  );

  assign mclk_o  = m_lvl & drive & ~park;
  assign bclk_o  = b_lvl & drive & ~park;
  assign wclk_o  = w_lvl & drive & ~park;
  assign mclk_oe = drive;
  assign bclk_oe = drive & act.master;
  assign wclk_oe = drive & act.master;

  // R8: enables only drop after a cycle of parked-low clocks
  a_r8_low_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mclk_oe) |-> ($past(mclk_o) == 1'b0 && $past(bclk_o) == 1'b0 && $past(wclk_o) == 1'b0));
  // R9: release and status arrive together
  a_r9_status_with_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mclk_oe) |-> stop_pend);
  // R6: bit/word enables never outlive the master clock enable
  a_r6_enable_nesting: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_oe || wclk_oe) |-> mclk_oe);
endmodule

// File: tb/test_aclk_gen.sv
module test_aclk_gen;
  import aclk_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n, cfg_wr, clk_en, stop_clr;
  logic [2:0]       ref_tick;
  logic [FMT_W-1:0] cfg_data;
  logic stop_pend, mclk_o, mclk_oe, bclk_o, bclk_oe, wclk_o, wclk_oe;

  aclk_gen i_aclk_gen (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .cfg_wr(cfg_wr),
    .cfg_data(cfg_data), .clk_en(clk_en), .stop_clr(stop_clr),
    .stop_pend(stop_pend), .mclk_o(mclk_o), .mclk_oe(mclk_oe),
    .bclk_o(bclk_o), .bclk_oe(bclk_oe), .wclk_o(wclk_o), .wclk_oe(wclk_oe)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // references strobe every 2, 3 and 4 cycles
  initial begin
    ref_tick = '0;
    forever begin
      @(negedge clk);
      ref_tick[0] = (cyc % 2 == 0);
      ref_tick[1] = (cyc % 3 == 0);
      ref_tick[2] = (cyc % 4 == 0);
    end
  end

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_up();
  end

  function automatic bit sig(input int w);
    case (w)
      0:       return mclk_o;
      1:       return bclk_o;
      default: return wclk_o;
    endcase
  endfunction

  task automatic wait_rise(input int w);
    bit prev;
    @(negedge clk);
    prev = sig(w);
    forever begin
      @(negedge clk);
      if (!prev && sig(w)) break;
      prev = sig(w);
    end
  endtask

  task automatic measure(input int w, output int per);
    int c0;
    wait_rise(w);
    c0 = cyc;
    wait_rise(w);
    per = cyc - c0;
  endtask

  function automatic logic [FMT_W-1:0] mk(input int src, input int mc, input int bc,
                                          input bit f64, input bit mst);
    fmt_t f;
    f.src = SRC_W'(src);
    f.mcode = MCODE_W'(mc);
    f.bcode = BCODE_W'(bc);
    f.frame64 = f64;
    f.master = mst;
    return f;
  endfunction

  // scoreboard of expected periods in system cycles
  typedef struct {int m; int b; int w; string tag;} exp_t;
  exp_t sb[$];

  task automatic push_exp(input int p, input int md, input int bd, input int fl, input string tag);
    exp_t e;
    e.m = 2 * md * p;
    e.b = e.m * bd;
    e.w = e.b * fl;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic monitor_pop();
    exp_t e;
    int per;
    e = sb.pop_front();
    measure(0, per); check(per == e.m, {e.tag, " R3 mclk period"}, per, e.m);
    measure(1, per); check(per == e.b, {e.tag, " R4 bclk period"}, per, e.b);
    measure(2, per); check(per == e.w, {e.tag, " R5 wclk period"}, per, e.w);
  endtask

  task automatic write_cfg(input logic [FMT_W-1:0] v);
    @(negedge clk); cfg_wr = 1; cfg_data = v;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic stop_and_clear();
    @(negedge clk); clk_en = 0;
    while (!stop_pend) @(negedge clk);
    stop_clr = 1;
    @(negedge clk); stop_clr = 0;
  endtask

  initial begin
    int rises, per;
    bit first, pb, pw, po, lm, lb, lw;
    rst_n = 0; cfg_wr = 0; cfg_data = '0; clk_en = 0; stop_clr = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check({mclk_oe, bclk_oe, wclk_oe} == 3'b000, "R1 enables", {mclk_oe, bclk_oe, wclk_oe}, 0);
    check({mclk_o, bclk_o, wclk_o} == 3'b000, "R1 levels", {mclk_o, bclk_o, wclk_o}, 0);
    check(stop_pend == 0, "R1 status", stop_pend, 0);

    // config A: ref0, M=1, B=1, 32-bit frame, master; R11 restart shape
    write_cfg(mk(0, 'h14, 'h8, 0, 1));
    @(negedge clk); clk_en = 1;
    rises = 0; first = 1; pb = 0; pw = 0;
    forever begin
      @(negedge clk);
      if (mclk_oe && first) begin
        check(wclk_o == 0, "R11 wclk low at start", wclk_o, 0);
        first = 0;
      end
      if (!pb && bclk_o) rises++;
      if (!pw && wclk_o) break;
      pb = bclk_o; pw = wclk_o;
    end
    check(rises == 16, "R11 half frame before wclk rise", rises, 16);
    check({mclk_oe, bclk_oe, wclk_oe} == 3'b111, "R6 master enables", {mclk_oe, bclk_oe, wclk_oe}, 7);
    push_exp(2, 1, 1, 32, "cfgA");
    monitor_pop();

    // R12 cancel the stop mid-frame
    wait_rise(2);
    clk_en = 0;
    repeat (10) @(negedge clk);
    clk_en = 1;
    repeat (400) @(negedge clk);
    check(mclk_oe == 1, "R12 still running", mclk_oe, 1);
    check(stop_pend == 0, "R12 no status", stop_pend, 0);

    // R7/R8/R9 stop at the frame boundary
    wait_rise(2);
    clk_en = 0;
    rises = 0; pb = 1; po = 1; lm = 0; lb = 0; lw = 0;
    forever begin
      @(negedge clk);
      if (po && !mclk_oe) break;
      if (!pb && bclk_o) rises++;
      pb = bclk_o; po = mclk_oe; lm = mclk_o; lb = bclk_o; lw = wclk_o;
    end
    check(rises == 16, "R7 bits finished before stop", rises, 16);
    check({lm, lb, lw} == 3'b000, "R8 parked low before release", {lm, lb, lw}, 0);
    check({bclk_oe, wclk_oe} == 2'b00, "R8 enables released", {bclk_oe, wclk_oe}, 0);
    check(stop_pend == 1, "R9 status set", stop_pend, 1);
    repeat (3) @(negedge clk);
    check(stop_pend == 1, "R9 status sticky", stop_pend, 1);
    stop_clr = 1;
    @(negedge clk); stop_clr = 0;
    @(negedge clk);
    check(stop_pend == 0, "R9 write-one clears", stop_pend, 0);

    // config B written while stopped (R10 immediate): ref1, M=3, B=3, 64-bit frame
    write_cfg(mk(1, 'h13, 'h9, 1, 1));
    @(negedge clk); clk_en = 1;
    push_exp(3, 3, 3, 64, "cfgB R2 R10");
    monitor_pop();

    // R10 write while running is held
    write_cfg(mk(2, 'h12, 'h0, 0, 0));
    measure(0, per);
    check(per == 18, "R10 held write has no effect yet", per, 18);
    stop_and_clear();
    @(negedge clk); clk_en = 1;
    repeat (4) @(negedge clk);
    check(mclk_oe == 1, "R6 slave mclk enable", mclk_oe, 1);
    check({bclk_oe, wclk_oe} == 2'b00, "R6 slave releases bit/word", {bclk_oe, wclk_oe}, 0);
    push_exp(4, 5, 2, 32, "cfgC R10 applied");
    monitor_pop();

    // config D: select code 3 aliases ref2, generic codes
    stop_and_clear();
    write_cfg(mk(3, 1, 2, 1, 1));
    @(negedge clk); clk_en = 1;
    push_exp(4, 4, 6, 64, "cfgD R2 alias");
    monitor_pop();

    finish_up();
  end
endmodule